// File: doc/BRIEF.md
# Inter-access bus idle cycle inserter

This block sits between a bus master's request stream and an external memory bus that has six chip-select spaces. Every space owns one configuration register. That register holds five 3-bit idle-count codes, one for each kind of transition from an access in that space to the next access. The block keeps the direction and space of the last accepted access. When the next request shows up, it classifies the transition and reads the matching code from the register of the previous access's space. It decodes that code into a cycle count and holds the request off for exactly that many cycles before accepting it.

Requests use a valid/ready handshake and carry a write flag and a 3-bit space index. A request counts as accepted in any cycle where both valid and ready are high. The idle period starts in the cycle the next request first appears. The configuration registers are read and written through a simple port: a write strobe, a 3-bit index, write data, and combinational read data.

Top module: `bus_idle_gap`

## Requirements
- R1: After reset, configuration registers 0 to 5 each read 0x36DB0000, so every idle-count field holds code 011.
- R2: Only bits 30:16 of a configuration register store writes. Bit 31 and bits 15:0 always read 0. Indexes 6 and 7 read 0, and writes to them change no register.
- R3: A 3-bit code gives these idle cycle counts: 0→0, 1→1, 2→2, 3→4, 4→6, 5→8, 6→10, 7→12.
- R4: After a write, the next access waits for the count in bits 30:28, whatever its direction or space.
- R5: After a read, a write to a different space waits for the count in bits 27:25.
- R6: After a read, a write to the same space waits for the count in bits 24:22.
- R7: After a read, a read to a different space waits for the count in bits 21:19, and a read to the same space waits for the count in bits 18:16.
- R8: The first request after reset is accepted with no idle cycles.
- R9: A request that arrives in the cycle after the previous acceptance has ready low for exactly the decoded number of cycles, then sees ready high.
- R10: A configuration write made during an idle period does not change that period. The new value applies from the next evaluated transition.
- R11: The count comes from the register of the previous access's space, not from the register of the space being requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the register at cfg_addr |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_space | input | 3 | Target chip-select space of the request |
| req_ready | output | 1 | Request accepted when high together with req_valid |

## Verification
The bench builds the block with its defaults: six spaces and a 3-bit space index. With these values the unused indexes 6 and 7 can be reached, and every register can be given its own field codes. The sweep runs all eight code offsets across every ordered pair of previous and next space and every direction pair, 1152 transitions in all. Because each space is programmed with different codes, the bench can tell which register supplied a count, which lets it check both the transition classification and the source register. Separate directed cases cover reset values, masking of reserved bits, the first access after reset, and a register rewrite made in the middle of an idle period.

// File: rtl/bus_idle_gap_pkg.sv
package bus_idle_gap_pkg;

  localparam int REG_W   = 32;
  localparam int FIELD_W = 3;
  localparam int IDLE_W  = 4;

  localparam logic [REG_W-1:0] CFG_KEEP_MASK = 32'h7FFF_0000;
  localparam logic [REG_W-1:0] CFG_RESET     = 32'h36DB_0000;

  typedef enum logic [2:0] {
    XFER_WR_ANY   = 3'd0,
    XFER_RW_OTHER = 3'd1,
    XFER_RW_SAME  = 3'd2,
    XFER_RR_OTHER = 3'd3,
    XFER_RR_SAME  = 3'd4
  } xfer_kind_e;

  // Sort a transition by the previous direction, the next direction and whether the space stays the same.
  function automatic xfer_kind_e classify(input logic prev_wr, input logic next_wr,
                                          input logic same_sp);
    if (prev_wr)      return XFER_WR_ANY;
    else if (next_wr) return same_sp ? XFER_RW_SAME : XFER_RW_OTHER;
    else              return same_sp ? XFER_RR_SAME : XFER_RR_OTHER;
  endfunction

  // Fields are packed downward from bit 28 in steps of three.
  function automatic int field_lsb(input xfer_kind_e kind);
    return 28 - FIELD_W * int'(kind);
  endfunction

  function automatic logic [IDLE_W-1:0] decode_idle(input logic [FIELD_W-1:0] code);
    case (code)
      3'd0:    return 4'd0;
      3'd1:    return 4'd1;
      3'd2:    return 4'd2;
      3'd3:    return 4'd4;
      3'd4:    return 4'd6;
      3'd5:    return 4'd8;
      3'd6:    return 4'd10;
      default: return 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/idle_cfg_regs.sv
module idle_cfg_regs
  import bus_idle_gap_pkg::*;
#(
  parameter int NUM_SPACES = 6,
  parameter int SPACE_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SPACE_W-1:0]               addr,
  input  logic [REG_W-1:0]                 wdata,
  output logic [REG_W-1:0]                 rdata,
  output logic [NUM_SPACES-1:0][REG_W-1:0] regs
);

  for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= CFG_RESET;
      else if (wr_en && addr == SPACE_W'(g))
        regs[g] <= wdata & CFG_KEEP_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SPACES; i++)
      if (addr == SPACE_W'(i)) rdata = regs[i];
  end

endmodule

// File: rtl/idle_gap_select.sv
module idle_gap_select
  import bus_idle_gap_pkg::*;
#(
  parameter int NUM_SPACES = 6,
  parameter int SPACE_W    = 3
) (
  input  logic [NUM_SPACES-1:0][REG_W-1:0] regs,
  input  logic                             prev_wr,
  input  logic [SPACE_W-1:0]               prev_sp,
  input  logic                             next_wr,
  input  logic [SPACE_W-1:0]               next_sp,
  output logic [IDLE_W-1:0]                gap
);

  logic [REG_W-1:0]   sel_reg;
  logic [FIELD_W-1:0] code;
  xfer_kind_e         kind;

  always_comb begin
    sel_reg = '0;
    for (int i = 0; i < NUM_SPACES; i++)
      if (prev_sp == SPACE_W'(i)) sel_reg = regs[i];
    kind = classify(prev_wr, next_wr, prev_sp == next_sp);
    code = sel_reg[field_lsb(kind) +: FIELD_W];
    gap  = decode_idle(code);
  end

endmodule

// File: rtl/idle_gap_counter.sv
module idle_gap_counter #(
  parameter int IDLE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDLE_W-1:0] load_val,
  output logic [IDLE_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - IDLE_W'(1);
  end

endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
  import bus_idle_gap_pkg::*;
#(
  parameter int NUM_SPACES = 6,
  parameter int SPACE_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [SPACE_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [SPACE_W-1:0] req_space,
  output logic               req_ready
);

  logic [NUM_SPACES-1:0][REG_W-1:0] cfg_regs;
  logic [IDLE_W-1:0] gap;
  logic [IDLE_W-1:0] idle_cnt;
  logic [IDLE_W-1:0] load_val;
  logic              fresh;      // an access was accepted and its successor is not yet evaluated
  logic              prev_wr;
  logic [SPACE_W-1:0] prev_sp;
  logic              gap_pending;
  logic              gap_load;
  logic              accept;

  idle_cfg_regs #(.NUM_SPACES(NUM_SPACES), .SPACE_W(SPACE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .regs(cfg_regs)
  );

  idle_gap_select #(.NUM_SPACES(NUM_SPACES), .SPACE_W(SPACE_W)) u_sel (
    .regs(cfg_regs), .prev_wr(prev_wr), .prev_sp(prev_sp),
    .next_wr(req_write), .next_sp(req_space), .gap(gap)
  );

  idle_gap_counter #(.IDLE_W(IDLE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(load_val), .cnt(idle_cnt)
  );

  // The cycle the request arrives is the first idle cycle, so the counter holds the remainder.
  assign gap_pending = fresh && req_valid && (gap != '0);
  assign gap_load    = gap_pending && (idle_cnt == '0);
  assign load_val    = gap - IDLE_W'(1);
  assign req_ready   = (idle_cnt == '0) && !gap_pending;
  assign accept      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh   <= 1'b0;
      prev_wr <= 1'b0;
      prev_sp <= '0;
    end else if (accept) begin
      fresh   <= 1'b1;
      prev_wr <= req_write;
      prev_sp <= req_space;
    end else if (gap_load) begin
      fresh   <= 1'b0;
    end
  end

endmodule

// File: rtl/bus_idle_gap_chk.sv
module bus_idle_gap_chk
  import bus_idle_gap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              fresh,
  input logic              load,
  input logic [IDLE_W-1:0] idle_cnt,
  input logic [REG_W-1:0]  cfg_rdata
);

  p_hold_while_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt != '0 |-> !req_ready);

  p_ready_when_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt == '0 && !fresh) |-> req_ready);

  p_countdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt != '0 && !load) |=> idle_cnt == $past(idle_cnt) - IDLE_W'(1));

  p_load_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> idle_cnt <= IDLE_W'(11));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~CFG_KEEP_MASK) == '0);

endmodule

bind bus_idle_gap bus_idle_gap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .fresh(fresh),
  .load(gap_load), .idle_cnt(idle_cnt), .cfg_rdata(cfg_rdata)
);

// File: tb/tb_bus_idle_gap.sv
`timescale 1ns/1ps
module tb_bus_idle_gap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_space = '0;
  logic        req_ready;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_idle_gap dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_write(req_write), .req_space(req_space), .req_ready(req_ready)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic int cycles_of(input int code);
    return (code <= 1) ? code : 2 * (code - 1);
  endfunction

  function automatic int code_of(input int c, input int k, input int s);
    return (c + k + s) % 8;
  endfunction

  function automatic logic [31:0] reg_of(input int c, input int s);
    logic [31:0] v = '0;
    for (int k = 0; k < 5; k++) v |= 32'(code_of(c, k, s)) << (28 - 3 * k);
    return v;
  endfunction

  // Called at a falling edge; returns at a falling edge.
  task automatic cfg_write(input int a, input logic [31:0] d);
    cfg_addr = 3'(a); cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input int a, output logic [31:0] d);
    cfg_addr = 3'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic access(input bit w, input int s, output int idle);
    req_valid = 1'b1; req_write = w; req_space = 3'(s); idle = 0;
    #1;
    while (!req_ready && idle < 40) begin
      @(negedge clk); #1; idle++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int idle;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int s = 0; s < 6; s++) begin
      cfg_read(s, rd);
      check("R1 reset value", rd, 32'h36DB_0000);
    end
    #1 check("R8 ready idle after reset", req_ready, 1);

    // R2: reserved bits and unused indexes
    @(negedge clk);
    cfg_write(2, 32'hFFFF_FFFF);
    cfg_read(2, rd);
    check("R2 reserved bits read zero", rd, 32'h7FFF_0000);
    cfg_write(6, 32'hFFFF_FFFF);
    cfg_write(7, 32'h1234_5678);
    cfg_read(6, rd);  check("R2 index 6 reads zero", rd, 0);
    cfg_read(7, rd);  check("R2 index 7 reads zero", rd, 0);
    for (int s = 0; s < 6; s++) begin
      cfg_read(s, rd);
      check("R2 unused index write ignored", rd, (s == 2) ? 32'h7FFF_0000 : 32'h36DB_0000);
    end
    @(negedge clk);

    // R8: first access after reset, then default code 011 after a write
    access(1'b1, 3, idle);
    check("R8 first access idle", idle, 0);
    access(1'b0, 3, idle);
    check("R1 R4 default write gap", idle, 4);

    // Sweep: R3 R4 R5 R6 R7 R9 R11
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 6; s++) cfg_write(s, reg_of(c, s));
      for (int ps = 0; ps < 6; ps++)
        for (int ns = 0; ns < 6; ns++)
          for (int dir = 0; dir < 4; dir++) begin
            bit pw = dir[1];
            bit nw = dir[0];
            int k;
            string tag;
            if (pw)      begin k = 0;                  tag = "R4 R3 R9 R11"; end
            else if (nw) begin k = (ps == ns) ? 2 : 1; tag = (ps == ns) ? "R6 R3 R9" : "R5 R3 R9 R11"; end
            else         begin k = (ps == ns) ? 4 : 3; tag = "R7 R3 R9 R11"; end
            access(pw, ps, idle);
            access(nw, ns, idle);
            check(tag, idle, cycles_of(code_of(c, k, ps)));
          end
    end

    // R10: rewrite during an idle period
    cfg_write(0, 32'h7000_0000);            // write-any field = 7, others 0
    access(1'b1, 0, idle);
    cfg_addr = 3'd0; cfg_wdata = 32'h0;
    req_valid = 1'b1; req_write = 1'b0; req_space = 3'd0; idle = 0;
    #1;
    while (!req_ready && idle < 40) begin
      @(negedge clk);
      cfg_wr = (idle == 3);
      #1; idle++;
    end
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    check("R10 idle kept during rewrite", idle, 12);
    access(1'b1, 0, idle);
    check("R10 new value applies next", idle, 0);
    access(1'b0, 0, idle);
    check("R10 rewritten write field", idle, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule